// File: doc/BRIEF.md
# Interval Timer Host Interface

This block is the bus-side front end of a three-channel interval timer. A host reaches it over an 8-bit bus through four ports: three per-channel data ports and one command port, selected by a 2-bit address, with single-cycle write and read strobes. Command bytes choose, per channel, how count bytes travel across the bus (low byte only, high byte only, or both bytes low first), the counting mode and the binary/BCD selection. Command bytes can also freeze a channel's count, or its status, for a later read.

The counter channels are not part of this block. Each one shows up as a live 16-bit count, an output-pin level and a loaded flag. The block returns a reload strobe with a 16-bit value once a channel's reload value is complete. It also drives each channel's counting mode and BCD selection so the counter logic can use them.

Top module: `tmr_host_if`

## Requirements
- R1: A command write (address 3) is decoded as follows. Bits 7-6 pick the channel (00, 01, 10). Bits 5-4 pick the operation: 00 latch count, 01 low byte only, 10 high byte only, 11 both bytes low first. Bits 3-1 are the counting mode and bit 0 is BCD (1) or binary (0). After an access-mode command, the mode and BCD outputs of the channel take the new values on the next cycle.
- R2: In low-byte-only access, a data write reloads the value {00, byte} and a read returns the low byte of the count. In high-byte-only access, a write reloads {byte, 00} and a read returns the high byte.
- R3: In two-byte access, writes take the low byte first and the high byte second. The reload happens only after the high byte. Reads also alternate low then high, and the read pointer is independent of the write pointer. An access-mode command sets both pointers back to the low byte.
- R4: The reload strobe for a channel rises in the cycle after the write that completes the value. It lasts exactly one cycle and carries the full 16-bit value.
- R5: A latch-count command (operation 00) captures the channel's count. Reads return the captured bytes while the live count moves on. Once the last byte the access mode requires has been read, reads return the live count again.
- R6: While a channel holds a latched count, access-mode and further count-latch commands to that channel have no effect. The mode and BCD bits of a latch-count command are always ignored.
- R7: Command code 1101 in bits 7-4 latches the count of every channel whose select bit is set: bit 1 is channel 0, bit 2 is channel 1, bit 3 is channel 2. Channels that are not selected keep reading live.
- R8: Command code 1110 latches the status byte of the selected channels, using the same select bits. The next read of that port returns the status, laid out as: bit 7 output pin, bit 6 loaded flag, bits 5-4 access (01 high only, 10 low only, 11 two-byte), bits 3-1 mode, bit 0 BCD. That read does not advance the byte pointer.
- R9: When a channel holds both a latched status and a latched count, the status byte is read first and the count bytes follow.
- R10: After reset every channel is in two-byte access, mode 0, binary, with both byte pointers on the low byte, no latches and no reload. Reads of the command port return 0. Command codes 1100 and 1111 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 2 | Port select: 0-2 channel data, 3 command |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for the addressed port (combinational) |
| cnt_in | input | 48 | Live count of each channel, channel i at bits 16i+15:16i |
| out_in | input | 3 | Output-pin level of each channel |
| loaded_in | input | 3 | Count-loaded flag of each channel |
| reload_o | output | 3 | One-cycle reload strobe per channel |
| reload_val_o | output | 48 | Reload value, channel i at bits 16i+15:16i |
| mode_o | output | 9 | Counting mode, channel i at bits 3i+2:3i |
| bcd_o | output | 3 | BCD selection per channel |

## Verification
Errors in the byte pointers show up at the ports within one or two reads or writes. A swapped low/high byte on rdata, or a reload strobe that comes one write early or late, is visible almost immediately. Errors in the latch state take longer to show: a latch that is not released, or a command that is wrongly ignored, only appears once the live count has moved away from the frozen value, or at the next command to that channel. The stimulus therefore changes the count inputs between a latch and its reads. It also reads the mode outputs after commands that should have been ignored.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [2:0]        mode;
        logic              bcd;
        logic              wr_hi;
        logic              rd_hi;
        logic              cnt_held;
        logic [CNT_W-1:0]  cnt_lat;
        logic              st_held;
        logic [BYTE_W-1:0] st_lat;
        logic [BYTE_W-1:0] lo_buf;
        logic              reload;
        logic [CNT_W-1:0]  reload_val;
    } chan_st_t;

    localparam chan_st_t CHAN_RST = '{acc: ACC_WORD, default: '0};
endpackage

// File: rtl/tmr_cmd_dec.sv
`timescale 1ns/1ps
module tmr_cmd_dec
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic [NUM_CH-1:0] acc_set,
    output logic [NUM_CH-1:0] cnt_lat,
    output logic [NUM_CH-1:0] st_lat,
    output acc_e              acc,
    output logic [2:0]        mode,
    output logic              bcd
);
    localparam logic [3:0] OP_MULTI_CNT = 4'b1101;
    localparam logic [3:0] OP_MULTI_ST  = 4'b1110;

    logic [3:0] op;

    always_comb begin
        op   = cmd_byte[7:4];
        acc  = acc_e'(op[1:0]);
        mode = cmd_byte[3:1];
        bcd  = cmd_byte[0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_comb begin
            acc_set[i] = cmd_we && (op[3:2] == 2'(i)) && (op[1:0] != ACC_LATCH);
            cnt_lat[i] = cmd_we && (((op[3:2] == 2'(i)) && (op[1:0] == ACC_LATCH))
                                   || ((op == OP_MULTI_CNT) && cmd_byte[i+1]));
            st_lat[i]  = cmd_we && (op == OP_MULTI_ST) && cmd_byte[i+1];
        end
    end
endmodule

// File: rtl/tmr_chan_port.sv
`timescale 1ns/1ps
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_set,
    input  logic              cnt_lat,
    input  logic              st_lat,
    input  acc_e              acc_in,
    input  logic [2:0]        mode_in,
    input  logic              bcd_in,
    input  logic              wr_sel,
    input  logic              rd_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              out_in,
    input  logic              loaded_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              reload_o,
    output logic [CNT_W-1:0]  reload_val_o,
    output logic [2:0]        mode_o,
    output logic              bcd_o
);
    chan_st_t q, d;
    logic [CNT_W-1:0]  src;
    logic [BYTE_W-1:0] cnt_byte;

    always_comb begin
        d        = q;
        d.reload = 1'b0;

        // byte presented on a read: held status first, then held or live count
        src = q.cnt_held ? q.cnt_lat : cnt_in;
        case (q.acc)
            ACC_LO:  cnt_byte = src[BYTE_W-1:0];
            ACC_HI:  cnt_byte = src[CNT_W-1:BYTE_W];
            default: cnt_byte = q.rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
        endcase
        rd_byte = q.st_held ? q.st_lat : cnt_byte;

        if (rd_sel) begin
            if (q.st_held) begin
                d.st_held = 1'b0;
            end else if (q.acc == ACC_WORD) begin
                d.rd_hi = !q.rd_hi;
                if (q.rd_hi) d.cnt_held = 1'b0;
            end else begin
                d.cnt_held = 1'b0;
            end
        end

        if (wr_sel) begin
            case (q.acc)
                ACC_LO: begin
                    d.reload     = 1'b1;
                    d.reload_val = {{BYTE_W{1'b0}}, wdata};
                end
                ACC_HI: begin
                    d.reload     = 1'b1;
                    d.reload_val = {wdata, {BYTE_W{1'b0}}};
                end
                default: begin
                    if (!q.wr_hi) begin
                        d.lo_buf = wdata;
                        d.wr_hi  = 1'b1;
                    end else begin
                        d.reload     = 1'b1;
                        d.reload_val = {wdata, q.lo_buf};
                        d.wr_hi      = 1'b0;
                    end
                end
            endcase
        end

        if (acc_set && !q.cnt_held) begin
            d.acc   = acc_in;
            d.mode  = mode_in;
            d.bcd   = bcd_in;
            d.wr_hi = 1'b0;
            d.rd_hi = 1'b0;
        end

        if (cnt_lat && !q.cnt_held) begin
            d.cnt_held = 1'b1;
            d.cnt_lat  = cnt_in;
        end

        if (st_lat && !q.st_held) begin
            d.st_held = 1'b1;
            // access field is encoded with the two bits swapped relative to the command
            d.st_lat  = {out_in, loaded_in, q.acc[0], q.acc[1], q.mode, q.bcd};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CHAN_RST;
        else        q <= d;
    end

    assign reload_o     = q.reload;
    assign reload_val_o = q.reload_val;
    assign mode_o       = q.mode;
    assign bcd_o        = q.bcd;
endmodule

// File: rtl/tmr_host_if.sv
`timescale 1ns/1ps
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [NUM_CH*CNT_W-1:0] cnt_in,
    input  logic [NUM_CH-1:0]       out_in,
    input  logic [NUM_CH-1:0]       loaded_in,
    output logic [NUM_CH-1:0]       reload_o,
    output logic [NUM_CH*CNT_W-1:0] reload_val_o,
    output logic [NUM_CH*3-1:0]     mode_o,
    output logic [NUM_CH-1:0]       bcd_o
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_CH);

    logic [NUM_CH-1:0] acc_set, cnt_lat, st_lat;
    acc_e              dec_acc;
    logic [2:0]        dec_mode;
    logic              dec_bcd;
    logic [BYTE_W-1:0] chan_rd [NUM_CH];

    tmr_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
        .cmd_we   (wr_en && (addr == CMD_ADDR)),
        .cmd_byte (wdata),
        .acc_set  (acc_set),
        .cnt_lat  (cnt_lat),
        .st_lat   (st_lat),
        .acc      (dec_acc),
        .mode     (dec_mode),
        .bcd      (dec_bcd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_chan_port u_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .acc_set      (acc_set[i]),
            .cnt_lat      (cnt_lat[i]),
            .st_lat       (st_lat[i]),
            .acc_in       (dec_acc),
            .mode_in      (dec_mode),
            .bcd_in       (dec_bcd),
            .wr_sel       (wr_en && (addr == ADDR_W'(i))),
            .rd_sel       (rd_en && (addr == ADDR_W'(i))),
            .wdata        (wdata),
            .cnt_in       (cnt_in[i*CNT_W +: CNT_W]),
            .out_in       (out_in[i]),
            .loaded_in    (loaded_in[i]),
            .rd_byte      (chan_rd[i]),
            .reload_o     (reload_o[i]),
            .reload_val_o (reload_val_o[i*CNT_W +: CNT_W]),
            .mode_o       (mode_o[i*3 +: 3]),
            .bcd_o        (bcd_o[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) rdata = chan_rd[i];
        end
    end
endmodule

// File: rtl/tmr_host_if_chk.sv
`timescale 1ns/1ps
module tmr_host_if_chk
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [BYTE_W-1:0]   rdata,
    input logic [NUM_CH-1:0]   reload_o,
    input logic [NUM_CH*3-1:0] mode_o,
    input logic [NUM_CH-1:0]   bcd_o
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_CH);

    // R4: at most one channel reloads per cycle
    a_r4_reload_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reload_o));

    // R1: mode and BCD only move after a command-port write
    a_r1_mode_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && (addr == CMD_ADDR)) |-> ($stable(mode_o) && $stable(bcd_o)));

    // R10: command port reads as zero
    a_r10_cmd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CMD_ADDR) |-> (rdata == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R4: a reload follows a write to that channel's data port
        a_r4_reload_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            reload_o[i] |-> ($past(wr_en) && ($past(addr) == ADDR_W'(i))));
    end
endmodule

bind tmr_host_if tmr_host_if_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .reload_o (reload_o),
    .mode_o   (mode_o),
    .bcd_o    (bcd_o)
);

// File: tb/tmr_host_if_tb.sv
`timescale 1ns/1ps
module tmr_host_if_tb;
    localparam int NUM_CH = 3;
    localparam int WD_CYCLES = 20000;

    localparam logic [2:0] OP_W = 3'd0;  // write byte
    localparam logic [2:0] OP_R = 3'd1;  // read and compare
    localparam logic [2:0] OP_S = 3'd2;  // set live count of a channel
    localparam logic [2:0] OP_C = 3'd3;  // reload strobe + value, then strobe gone
    localparam logic [2:0] OP_Q = 3'd4;  // no reload strobe
    localparam logic [2:0] OP_M = 3'd5;  // {mode,bcd} of a channel

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  ch;
        logic [15:0] val;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NT = 58;
    localparam vec_t TBL [NT] = '{
        '{OP_R, 2'd0, 16'h0000, 16'h0034, 4'd10}, // R10 reset: two-byte, low first
        '{OP_R, 2'd0, 16'h0000, 16'h0012, 4'd10},
        '{OP_R, 2'd3, 16'h0000, 16'h0000, 4'd10}, // R10 command port reads 0
        '{OP_W, 2'd3, 16'h0010, 16'h0000, 4'd2},  // ch0 low only
        '{OP_R, 2'd0, 16'h0000, 16'h0034, 4'd2},  // R2
        '{OP_W, 2'd0, 16'h0077, 16'h0000, 4'd2},
        '{OP_C, 2'd0, 16'h0000, 16'h0077, 4'd2},
        '{OP_W, 2'd3, 16'h0020, 16'h0000, 4'd2},  // ch0 high only
        '{OP_R, 2'd0, 16'h0000, 16'h0012, 4'd2},
        '{OP_W, 2'd0, 16'h0099, 16'h0000, 4'd2},
        '{OP_C, 2'd0, 16'h0000, 16'h9900, 4'd2},
        '{OP_W, 2'd3, 16'h0034, 16'h0000, 4'd3},  // R3 ch0 two-byte mode 2
        '{OP_W, 2'd0, 16'h00AA, 16'h0000, 4'd3},
        '{OP_Q, 2'd0, 16'h0000, 16'h0000, 4'd3},
        '{OP_W, 2'd0, 16'h00BB, 16'h0000, 4'd3},
        '{OP_C, 2'd0, 16'h0000, 16'hBBAA, 4'd4},  // R4
        '{OP_W, 2'd3, 16'h0000, 16'h0000, 4'd5},  // R5 latch ch0
        '{OP_S, 2'd0, 16'h5678, 16'h0000, 4'd5},
        '{OP_R, 2'd0, 16'h0000, 16'h0034, 4'd5},
        '{OP_R, 2'd0, 16'h0000, 16'h0012, 4'd5},
        '{OP_R, 2'd0, 16'h0000, 16'h0078, 4'd5},  // live again
        '{OP_R, 2'd0, 16'h0000, 16'h0056, 4'd5},
        '{OP_W, 2'd3, 16'h000E, 16'h0000, 4'd6},  // R6 latch, mode bits 111
        '{OP_W, 2'd3, 16'h0010, 16'h0000, 4'd6},  // ignored while held
        '{OP_S, 2'd0, 16'h1111, 16'h0000, 4'd6},
        '{OP_R, 2'd0, 16'h0000, 16'h0078, 4'd6},
        '{OP_R, 2'd0, 16'h0000, 16'h0056, 4'd6},
        '{OP_M, 2'd0, 16'h0000, 16'h0004, 4'd6},
        '{OP_W, 2'd3, 16'h00D6, 16'h0000, 4'd7},  // R7 latch ch1+ch0
        '{OP_S, 2'd0, 16'h2222, 16'h0000, 4'd7},
        '{OP_S, 2'd1, 16'h3333, 16'h0000, 4'd7},
        '{OP_S, 2'd2, 16'h0D0C, 16'h0000, 4'd7},
        '{OP_R, 2'd1, 16'h0000, 16'h00CD, 4'd7},
        '{OP_R, 2'd1, 16'h0000, 16'h00AB, 4'd7},
        '{OP_R, 2'd0, 16'h0000, 16'h0011, 4'd7},
        '{OP_R, 2'd0, 16'h0000, 16'h0011, 4'd7},
        '{OP_R, 2'd0, 16'h0000, 16'h0022, 4'd7},
        '{OP_R, 2'd0, 16'h0000, 16'h0022, 4'd7},
        '{OP_R, 2'd2, 16'h0000, 16'h000C, 4'd7},  // ch2 was not selected
        '{OP_R, 2'd2, 16'h0000, 16'h000D, 4'd7},
        '{OP_W, 2'd3, 16'h00E4, 16'h0000, 4'd8},  // R8 status ch1
        '{OP_R, 2'd1, 16'h0000, 16'h0070, 4'd8},
        '{OP_R, 2'd1, 16'h0000, 16'h0033, 4'd8},
        '{OP_W, 2'd3, 16'h00E2, 16'h0000, 4'd9},  // R9 status then count ch0
        '{OP_W, 2'd3, 16'h0000, 16'h0000, 4'd9},
        '{OP_S, 2'd0, 16'h4444, 16'h0000, 4'd9},
        '{OP_R, 2'd0, 16'h0000, 16'h00F4, 4'd9},
        '{OP_R, 2'd0, 16'h0000, 16'h0022, 4'd9},
        '{OP_R, 2'd0, 16'h0000, 16'h0022, 4'd9},
        '{OP_R, 2'd0, 16'h0000, 16'h0044, 4'd9},
        '{OP_W, 2'd3, 16'h0055, 16'h0000, 4'd1},  // R1 ch1 low only, mode 2, BCD
        '{OP_M, 2'd1, 16'h0000, 16'h0005, 4'd1},
        '{OP_W, 2'd3, 16'h00E4, 16'h0000, 4'd1},
        '{OP_R, 2'd1, 16'h0000, 16'h0065, 4'd1},
        '{OP_W, 2'd3, 16'h00F2, 16'h0000, 4'd10}, // R10 unused codes
        '{OP_W, 2'd3, 16'h00C2, 16'h0000, 4'd10},
        '{OP_R, 2'd0, 16'h0000, 16'h0044, 4'd10},
        '{OP_M, 2'd0, 16'h0000, 16'h0004, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] cnt_in = {16'h0F0E, 16'hABCD, 16'h1234};
    logic [2:0]  out_in = 3'b101;
    logic [2:0]  loaded_in = 3'b111;
    logic [2:0]  reload_o;
    logic [47:0] reload_val_o;
    logic [8:0]  mode_o;
    logic [2:0]  bcd_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_in(cnt_in), .out_in(out_in),
        .loaded_in(loaded_in), .reload_o(reload_o), .reload_val_o(reload_val_o),
        .mode_o(mode_o), .bcd_o(bcd_o)
    );

    task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_op(input vec_t v);
        logic [7:0] got;
        case (v.op)
            OP_W: begin
                @(negedge clk); addr = v.ch; wdata = v.val[7:0]; wr_en = 1'b1;
                @(negedge clk); wr_en = 1'b0;
            end
            OP_R: begin
                @(negedge clk); addr = v.ch; rd_en = 1'b1;
                #1 got = rdata;
                @(negedge clk); rd_en = 1'b0;
                check(int'(v.req), {8'h00, got}, v.exp);
            end
            OP_S: cnt_in[v.ch*16 +: 16] = v.val;
            OP_C: begin
                check(int'(v.req), {15'd0, reload_o[v.ch]}, 16'd1);
                check(int'(v.req), reload_val_o[v.ch*16 +: 16], v.exp);
                @(negedge clk);
                check(4, {15'd0, reload_o[v.ch]}, 16'd0); // R4 single-cycle strobe
            end
            OP_Q: check(int'(v.req), {15'd0, reload_o[v.ch]}, 16'd0);
            OP_M: check(int'(v.req), {12'd0, mode_o[v.ch*3 +: 3], bcd_o[v.ch]}, v.exp);
            default: ;
        endcase
    endtask

    task automatic op(input logic [2:0] o, input logic [1:0] c, input logic [15:0] val,
                      input logic [15:0] exp, input logic [3:0] req);
        do_op('{o, c, val, exp, req});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state of strobes and mode outputs
        check(10, {13'd0, reload_o}, 16'd0);
        check(10, {7'd0, mode_o}, 16'd0);
        check(10, {13'd0, bcd_o}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NT; i++) do_op(TBL[i]);

        // R3: ch2 read and write pointers run independently
        op(OP_W, 2'd2, 16'h0001, 16'h0000, 4'd3);
        op(OP_R, 2'd2, 16'h0000, 16'h000C, 4'd3);
        op(OP_Q, 2'd2, 16'h0000, 16'h0000, 4'd3);
        op(OP_R, 2'd2, 16'h0000, 16'h000D, 4'd3);
        op(OP_W, 2'd2, 16'h0002, 16'h0000, 4'd3);
        op(OP_C, 2'd2, 16'h0000, 16'h0201, 4'd3);
        // R3: access-mode command brings the write pointer back to the low byte
        op(OP_W, 2'd2, 16'h0005, 16'h0000, 4'd3);
        op(OP_W, 2'd3, 16'h00B0, 16'h0000, 4'd3);
        op(OP_W, 2'd2, 16'h0006, 16'h0000, 4'd3);
        op(OP_Q, 2'd2, 16'h0000, 16'h0000, 4'd3);
        op(OP_W, 2'd2, 16'h0007, 16'h0000, 4'd3);
        op(OP_C, 2'd2, 16'h0000, 16'h0706, 4'd3);

        // R10: reset drops a held count
        op(OP_W, 2'd3, 16'h0000, 16'h0000, 4'd10);
        op(OP_S, 2'd0, 16'h9A3C, 16'h0000, 4'd10);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        op(OP_R, 2'd0, 16'h0000, 16'h003C, 4'd10);
        op(OP_M, 2'd1, 16'h0000, 16'h0000, 4'd10);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule